// File: doc/BRIEF.md
# Pending Store Queue with Load Forwarding

This block sits between a processor pipeline and a slow memory write port. It holds stores that the pipeline treats as already finished. A store is accepted with its address. Its data may come with it or be delivered later by entry index over a separate fill port. Pending entries are written to memory strictly oldest first, one transaction at a time, under a valid/ready handshake. An entry whose data has not arrived blocks the drain at the head.

Loads query the queue in the same cycle through a combinational lookup port. The lookup reports one of three results. A hit returns the value of the youngest pending store to the same word address. A stall means that youngest matching store has no data yet. A miss means the load may go to memory. When every slot is occupied, the store input drops ready. A fence request closes the store input until every earlier entry has drained.

Two named states govern store acceptance. In OPEN, stores are taken whenever a slot is free. HOLD is entered from OPEN (transition OPEN→HOLD) in any cycle where fence_req is high, and stores are refused in that same cycle. The queue returns from HOLD to OPEN (transition HOLD→OPEN) at the first clock edge where the queue is empty and fence_req is low. A fence_req that arrives while in HOLD keeps the queue in HOLD.

Top module: `pending_store_queue`

## Requirements
- R1: While the queue is in OPEN, is not full and fence_req is low, st_ready is high. An accepted store takes the slot reported on st_idx. Slots are handed out in ascending order modulo DEPTH, starting from 0 after reset.
- R2: Entries go to memory in acceptance order. While mem_valid is high and mem_ready is low, mem_valid, mem_addr and mem_data hold steady. mem_valid is never high while the queue is empty.
- R3: When all DEPTH slots are occupied, st_ready is low and no store is accepted.
- R4: When ld_valid is high, exactly one of ld_hit, ld_miss and ld_stall is high. When ld_valid is low, all three are low. ld_miss is reported when no pending entry has the load address.
- R5: When several pending entries match the load address, ld_hit returns the data of the most recently accepted one.
- R6: When the most recently accepted matching entry has no data yet, ld_stall is high, even if an older match holds data.
- R7: A fill with fill_valid high writes fill_data into pending slot fill_idx and marks it as having data. From the next cycle on, that slot forwards and drains with this value.
- R8: The head entry is not offered to memory (mem_valid low) until its data is present.
- R9: From the cycle fence_req is high until the queue has fully drained, st_ready is low. The queue reopens in the cycle after it is first seen empty.
- R10: An entry stays visible to lookups up to and including the cycle in which memory accepts it.
- R11: After reset the queue is empty, st_ready is high, mem_valid is low, and every lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store request |
| st_ready | output | 1 | Store accepted this cycle when high with st_valid |
| st_addr | input | ADDR_W | Word address of the store |
| st_data | input | DATA_W | Store data, used when st_data_ok is high |
| st_data_ok | input | 1 | Data comes with the store |
| st_idx | output | $clog2(DEPTH) | Slot the store is placed in |
| fill_valid | input | 1 | Late data delivery |
| fill_idx | input | $clog2(DEPTH) | Slot receiving late data |
| fill_data | input | DATA_W | Late data value |
| fence_req | input | 1 | Block later stores until the queue is empty |
| mem_valid | output | 1 | Head entry offered to memory |
| mem_ready | input | 1 | Memory accepts the offered entry |
| mem_addr | output | ADDR_W | Address of the head entry |
| mem_data | output | DATA_W | Data of the head entry |
| ld_valid | input | 1 | Load lookup request |
| ld_addr | input | ADDR_W | Load word address |
| ld_hit | output | 1 | Forwarded data valid |
| ld_miss | output | 1 | No pending match, go to memory |
| ld_stall | output | 1 | Youngest match still awaits data |
| ld_data | output | DATA_W | Forwarded data, zero unless hit |

## Verification
The bench builds the queue with DEPTH=4, ADDR_W=8 and DATA_W=16. With four slots, a short stimulus table fills the queue, stacks three stores to one address and leaves one of them waiting for data. It also wraps the slot index back to 0 before the fence test. This lets the youngest-match priority, the stall on a pending youngest match, the full back-pressure, the blocked head and the fence hold-and-reopen all be reached in a few dozen cycles.

// File: rtl/psq_pkg.sv
package psq_pkg;
    typedef enum logic {
        FS_OPEN = 1'b0,
        FS_HOLD = 1'b1
    } fence_state_e;

    typedef enum logic [1:0] {
        LK_MISS  = 2'd0,
        LK_HIT   = 2'd1,
        LK_STALL = 2'd2
    } lookup_res_e;
endpackage

// File: rtl/psq_entries.sv
module psq_entries #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc,
    input  logic [ADDR_W-1:0] alloc_addr,
    input  logic [DATA_W-1:0] alloc_data,
    input  logic              alloc_has_data,
    input  logic              fill_en,
    input  logic [IDX_W-1:0]  fill_slot,
    input  logic [DATA_W-1:0] fill_val,
    input  logic              pop,
    output logic [DEPTH-1:0]  vld,
    output logic [DEPTH-1:0]  has_data,
    output logic [ADDR_W-1:0] addr_arr [DEPTH],
    output logic [DATA_W-1:0] data_arr [DEPTH],
    output logic [IDX_W-1:0]  head_slot,
    output logic [IDX_W-1:0]  tail_slot,
    output logic              full,
    output logic              empty
);
    logic [IDX_W:0] head_q, tail_q;

    assign head_slot = head_q[IDX_W-1:0];
    assign tail_slot = tail_q[IDX_W-1:0];
    assign empty     = (head_q == tail_q);
    assign full      = (head_q[IDX_W] != tail_q[IDX_W]) &&
                       (head_q[IDX_W-1:0] == tail_q[IDX_W-1:0]);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q   <= '0;
            tail_q   <= '0;
            vld      <= '0;
            has_data <= '0;
        end else begin
            if (pop) begin
                vld[head_slot] <= 1'b0;
                head_q         <= head_q + 1'b1;
            end
            if (fill_en && vld[fill_slot] && !has_data[fill_slot]) begin
                has_data[fill_slot] <= 1'b1;
            end
            if (alloc) begin
                vld[tail_slot]      <= 1'b1;
                has_data[tail_slot] <= alloc_has_data;
                tail_q              <= tail_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en && vld[fill_slot] && !has_data[fill_slot]) begin
            data_arr[fill_slot] <= fill_val;
        end
        if (alloc) begin
            addr_arr[tail_slot] <= alloc_addr;
            data_arr[tail_slot] <= alloc_data;
        end
    end
endmodule

// File: rtl/psq_fwd_search.sv
module psq_fwd_search #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0]  vld,
    input  logic [DEPTH-1:0]  has_data,
    input  logic [ADDR_W-1:0] addr_arr [DEPTH],
    input  logic [DATA_W-1:0] data_arr [DEPTH],
    input  logic [IDX_W-1:0]  head_slot,
    input  logic              ld_valid,
    input  logic [ADDR_W-1:0] ld_addr,
    output psq_pkg::lookup_res_e res,
    output logic [DATA_W-1:0] fwd_data
);
    import psq_pkg::*;

    logic              found;
    logic              found_rdy;
    logic [DATA_W-1:0] found_data;

    // Walk from oldest to youngest; a later match overwrites an earlier one.
    always_comb begin
        logic [IDX_W-1:0] slot;
        found      = 1'b0;
        found_rdy  = 1'b0;
        found_data = '0;
        for (int k = 0; k < DEPTH; k++) begin
            slot = head_slot + IDX_W'(k);
            if (vld[slot] && (addr_arr[slot] == ld_addr)) begin
                found      = 1'b1;
                found_rdy  = has_data[slot];
                found_data = data_arr[slot];
            end
        end
    end

    always_comb begin
        res      = LK_MISS;
        fwd_data = '0;
        if (ld_valid && found) begin
            if (found_rdy) begin
                res      = LK_HIT;
                fwd_data = found_data;
            end else begin
                res = LK_STALL;
            end
        end
    end
endmodule

// File: rtl/psq_fence_fsm.sv
module psq_fence_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic fence_req,
    input  logic q_empty,
    input  logic q_full,
    output logic store_ok
);
    import psq_pkg::*;

    fence_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FS_OPEN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FS_OPEN: if (fence_req) state_d = FS_HOLD;
            FS_HOLD: if (q_empty && !fence_req) state_d = FS_OPEN;
        endcase
    end

    always_comb begin
        store_ok = 1'b0;
        unique case (state_q)
            FS_OPEN: store_ok = !fence_req && !q_full;
            FS_HOLD: store_ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/pending_store_queue.sv
module pending_store_queue #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_valid,
    output logic              st_ready,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [DATA_W-1:0] st_data,
    input  logic              st_data_ok,
    output logic [IDX_W-1:0]  st_idx,
    input  logic              fill_valid,
    input  logic [IDX_W-1:0]  fill_idx,
    input  logic [DATA_W-1:0] fill_data,
    input  logic              fence_req,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_data,
    input  logic              ld_valid,
    input  logic [ADDR_W-1:0] ld_addr,
    output logic              ld_hit,
    output logic              ld_miss,
    output logic              ld_stall,
    output logic [DATA_W-1:0] ld_data
);
    import psq_pkg::*;

    logic [DEPTH-1:0]  vld, has_data;
    logic [ADDR_W-1:0] addr_arr [DEPTH];
    logic [DATA_W-1:0] data_arr [DEPTH];
    logic [IDX_W-1:0]  head_slot, tail_slot;
    logic              q_full, q_empty;
    logic              accept, pop;
    lookup_res_e       lk_res;

    assign accept    = st_valid && st_ready;
    assign st_idx    = tail_slot;
    assign mem_valid = vld[head_slot] && has_data[head_slot];
    assign mem_addr  = addr_arr[head_slot];
    assign mem_data  = data_arr[head_slot];
    assign pop       = mem_valid && mem_ready;

    assign ld_hit   = (lk_res == LK_HIT);
    assign ld_stall = (lk_res == LK_STALL);
    assign ld_miss  = ld_valid && (lk_res == LK_MISS);

    psq_entries #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) entries_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .alloc         (accept),
        .alloc_addr    (st_addr),
        .alloc_data    (st_data),
        .alloc_has_data(st_data_ok),
        .fill_en       (fill_valid),
        .fill_slot     (fill_idx),
        .fill_val      (fill_data),
        .pop           (pop),
        .vld           (vld),
        .has_data      (has_data),
        .addr_arr      (addr_arr),
        .data_arr      (data_arr),
        .head_slot     (head_slot),
        .tail_slot     (tail_slot),
        .full          (q_full),
        .empty         (q_empty)
    );

    psq_fwd_search #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) search_i (
        .vld      (vld),
        .has_data (has_data),
        .addr_arr (addr_arr),
        .data_arr (data_arr),
        .head_slot(head_slot),
        .ld_valid (ld_valid),
        .ld_addr  (ld_addr),
        .res      (lk_res),
        .fwd_data (ld_data)
    );

    psq_fence_fsm fence_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .fence_req(fence_req),
        .q_empty  (q_empty),
        .q_full   (q_full),
        .store_ok (st_ready)
    );
endmodule

// File: rtl/psq_checker.sv
module psq_checker #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              st_valid,
    input logic              st_ready,
    input logic              fence_req,
    input logic              mem_valid,
    input logic              mem_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_data,
    input logic              ld_valid,
    input logic              ld_hit,
    input logic              ld_miss,
    input logic              ld_stall
);
    logic [IDX_W:0] cnt_q;
    logic           fence_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            fence_q <= 1'b0;
        end else begin
            cnt_q <= cnt_q + (IDX_W+1)'(st_valid && st_ready)
                           - (IDX_W+1)'(mem_valid && mem_ready);
            if (fence_req)         fence_q <= 1'b1;
            else if (cnt_q == '0)  fence_q <= 1'b0;
        end
    end

    p_ready_open_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!fence_q && !fence_req && (cnt_q < (IDX_W+1)'(DEPTH))) |-> st_ready);

    p_mem_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data)));

    p_no_drain_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> (cnt_q != '0));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_ready |-> (cnt_q < (IDX_W+1)'(DEPTH)));

    p_one_outcome_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |-> ($countones({ld_hit, ld_miss, ld_stall}) == 1));

    p_quiet_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_valid |-> !(ld_hit || ld_miss || ld_stall));

    p_fence_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fence_q || fence_req) |-> !st_ready);
endmodule

bind pending_store_queue psq_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .st_valid (st_valid),
    .st_ready (st_ready),
    .fence_req(fence_req),
    .mem_valid(mem_valid),
    .mem_ready(mem_ready),
    .mem_addr (mem_addr),
    .mem_data (mem_data),
    .ld_valid (ld_valid),
    .ld_hit   (ld_hit),
    .ld_miss  (ld_miss),
    .ld_stall (ld_stall)
);

// File: tb/pending_store_queue_tb_top.sv
module pending_store_queue_tb_top;
    localparam int AW = 8;
    localparam int DW = 16;
    localparam int DP = 4;
    localparam int IW = $clog2(DP);

    // Vector: {op[1:0], addr[7:0], data[15:0], exp[1:0]}
    // op 0 store with data, 1 store without data, 2 load, 3 fill (addr[1:0] = slot)
    // exp: store -> expected slot; load -> 0 miss, 1 hit, 2 stall
    localparam int NV = 14;
    localparam logic [27:0] VEC [NV] = '{
        {2'd2, 8'h10, 16'h0000, 2'd0},
        {2'd0, 8'h10, 16'h1111, 2'd0},
        {2'd2, 8'h10, 16'h1111, 2'd1},
        {2'd1, 8'h20, 16'h0000, 2'd1},
        {2'd2, 8'h20, 16'h0000, 2'd2},
        {2'd0, 8'h10, 16'h2222, 2'd2},
        {2'd2, 8'h10, 16'h2222, 2'd1},
        {2'd3, 8'h01, 16'h3333, 2'd0},
        {2'd2, 8'h20, 16'h3333, 2'd1},
        {2'd2, 8'h30, 16'h0000, 2'd0},
        {2'd1, 8'h10, 16'h0000, 2'd3},
        {2'd2, 8'h10, 16'h0000, 2'd2},
        {2'd3, 8'h03, 16'h4444, 2'd0},
        {2'd2, 8'h10, 16'h4444, 2'd1}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          st_valid = 1'b0, st_data_ok = 1'b0, fill_valid = 1'b0;
    logic          fence_req = 1'b0, mem_ready = 1'b0, ld_valid = 1'b0;
    logic [AW-1:0] st_addr = '0, ld_addr = '0;
    logic [DW-1:0] st_data = '0, fill_data = '0;
    logic [IW-1:0] fill_idx = '0;
    logic          st_ready, mem_valid, ld_hit, ld_miss, ld_stall;
    logic [IW-1:0] st_idx;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_data, ld_data;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pending_store_queue #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(DP)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr),
        .st_data(st_data), .st_data_ok(st_data_ok), .st_idx(st_idx),
        .fill_valid(fill_valid), .fill_idx(fill_idx), .fill_data(fill_data),
        .fence_req(fence_req),
        .mem_valid(mem_valid), .mem_ready(mem_ready),
        .mem_addr(mem_addr), .mem_data(mem_data),
        .ld_valid(ld_valid), .ld_addr(ld_addr),
        .ld_hit(ld_hit), .ld_miss(ld_miss), .ld_stall(ld_stall), .ld_data(ld_data)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        st_valid = 0; st_data_ok = 0; fill_valid = 0; fence_req = 0;
        mem_ready = 0; ld_valid = 0;
    endtask

    task automatic step_in();
        @(negedge clk);
        idle();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        n_run++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R11: reset state
        step_in();
        ld_valid = 1; ld_addr = 8'h10;
        #2;
        chk("R11 st_ready after reset", 32'(st_ready), 32'd1);
        chk("R11 mem_valid after reset", 32'(mem_valid), 32'd0);
        chk("R11 lookup misses after reset", 32'({ld_hit, ld_miss, ld_stall}), 32'b010);

        // Table walk, memory held off
        for (int i = 0; i < NV; i++) begin
            logic [27:0] v;
            v = VEC[i];
            step_in();
            unique case (v[27:26])
                2'd0, 2'd1: begin
                    st_valid = 1; st_addr = v[25:18]; st_data = v[17:2];
                    st_data_ok = (v[27:26] == 2'd0);
                    #2;
                    chk($sformatf("R1 vec%0d st_ready", i), 32'(st_ready), 32'd1);
                    chk($sformatf("R1 vec%0d st_idx", i), 32'(st_idx), 32'(v[1:0]));
                end
                2'd2: begin
                    ld_valid = 1; ld_addr = v[25:18];
                    #2;
                    // R4 R5 R6 R7: outcome and forwarded data
                    chk($sformatf("R5 R6 vec%0d outcome", i),
                        32'({ld_hit, ld_miss, ld_stall}),
                        (v[1:0] == 2'd1) ? 32'b100 : (v[1:0] == 2'd2) ? 32'b001 : 32'b010);
                    if (v[1:0] == 2'd1)
                        chk($sformatf("R7 vec%0d ld_data", i), 32'(ld_data), 32'(v[17:2]));
                end
                2'd3: begin
                    fill_valid = 1; fill_idx = v[19:18]; fill_data = v[17:2];
                    #2;
                end
            endcase
        end

        // R3: full
        step_in();
        st_valid = 1; st_addr = 8'h50; st_data_ok = 1; st_data = 16'hdead;
        #2;
        chk("R3 st_ready low when full", 32'(st_ready), 32'd0);
        chk("R2 head offered", 32'({mem_valid, mem_addr}), 32'({1'b1, 8'h10}));
        step_in();
        #2;
        chk("R2 head held without ready", 32'({mem_valid, mem_addr, mem_data}),
            32'({1'b1, 8'h10, 16'h1111}));

        // R2 drain order, R10 lookup on the draining entry
        begin
            logic [23:0] exp_seq [4];
            exp_seq[0] = {8'h10, 16'h1111};
            exp_seq[1] = {8'h20, 16'h3333};
            exp_seq[2] = {8'h10, 16'h2222};
            exp_seq[3] = {8'h10, 16'h4444};
            for (int d = 0; d < 4; d++) begin
                step_in();
                mem_ready = 1;
                if (d == 1) begin ld_valid = 1; ld_addr = 8'h20; end
                #2;
                chk($sformatf("R2 drain %0d", d), 32'({mem_valid, mem_addr, mem_data}),
                    32'({1'b1, exp_seq[d]}));
                if (d == 1)
                    chk("R10 hit while draining", 32'({ld_hit, ld_data}), 32'({1'b1, 16'h3333}));
            end
        end
        step_in();
        mem_ready = 1;
        #2;
        chk("R2 no offer when empty", 32'(mem_valid), 32'd0);

        // R8 head blocked until data; R1 slot wrap to 0
        step_in();
        st_valid = 1; st_addr = 8'h40; st_data_ok = 0;
        #2;
        chk("R1 slot wraps to 0", 32'({st_ready, st_idx}), 32'({1'b1, 2'd0}));
        for (int w = 0; w < 2; w++) begin
            step_in();
            mem_ready = 1;
            #2;
            chk("R8 head without data not offered", 32'(mem_valid), 32'd0);
        end
        step_in();
        mem_ready = 1; fill_valid = 1; fill_idx = 2'd0; fill_data = 16'h5555;
        #2;
        chk("R8 not offered in fill cycle", 32'(mem_valid), 32'd0);
        step_in();
        mem_ready = 1;
        #2;
        chk("R7 R8 filled head drains", 32'({mem_valid, mem_addr, mem_data}),
            32'({1'b1, 8'h40, 16'h5555}));

        // R9 fence
        step_in();
        st_valid = 1; st_addr = 8'h60; st_data_ok = 1; st_data = 16'h6060;
        #2;
        chk("R1 store A slot", 32'({st_ready, st_idx}), 32'({1'b1, 2'd1}));
        step_in();
        st_valid = 1; st_addr = 8'h61; st_data_ok = 1; st_data = 16'h6161;
        #2;
        chk("R1 store B slot", 32'({st_ready, st_idx}), 32'({1'b1, 2'd2}));
        step_in();
        fence_req = 1; st_valid = 1; st_addr = 8'h62; st_data_ok = 1;
        #2;
        chk("R9 refused in fence cycle", 32'(st_ready), 32'd0);
        for (int f = 0; f < 2; f++) begin
            step_in();
            st_valid = 1; st_addr = 8'h62; st_data_ok = 1; mem_ready = 1;
            #2;
            chk("R9 refused while draining", 32'(st_ready), 32'd0);
        end
        step_in();
        mem_ready = 1;
        #2;
        chk("R9 queue drained", 32'(mem_valid), 32'd0);
        step_in();
        st_valid = 1; st_addr = 8'h62; st_data_ok = 1; st_data = 16'h6262;
        #2;
        chk("R9 reopened after drain", 32'({st_ready, st_idx}), 32'({1'b1, 2'd3}));
        step_in();
        ld_valid = 1; ld_addr = 8'h61;
        #2;
        chk("R4 drained address misses", 32'({ld_hit, ld_miss, ld_stall}), 32'b010);

        step_in();
        #20;
        finish_run();
    end
endmodule